// File: doc/BRIEF.md
# Priority Reference Clock Selector

This block decides which of several reference clock inputs feeds a downstream clock-synthesis loop. It works on control levels only. Each input has a loss-of-signal alarm and a frequency-offset alarm, and both arrive as synchronous levels. Either alarm marks the input as unusable. An alarm level change counts only after it has been held steady for a set number of clocks, so short glitches on an alarm do not move the selection. The block does not multiplex clocks and does not detect alarms itself.

In manual mode a select code picks the input directly. In automatic mode the block picks by fixed priority: the lowest index has the highest priority. When the chosen input fails, the block moves to the next usable input of lower priority. A return to a recovered input of higher priority happens only while the revert control is high. When no input is usable, the block keeps its selection and raises a hold request. The outputs are:
- an encoded selection,
- one-hot "active" indicators, which stay valid while the loop is in digital hold,
- "in use" indicators that are masked by the hold flag,
- a one-cycle pulse on every change of selection.

Undriven control inputs are expected to be tied low, so manual selection of input 0 with revert off is the default.

Top module: `refclk_prio_sel`

## Requirements
- R1: After reset, sel_idx is 0, active is 3'b001, and hold_req and switch_pulse are 0. All inputs count as usable until an alarm is qualified.
- R2: While auto_en is low, sel_idx follows man_sel one clock later: code 0 selects input 0, code 1 selects input 1, code 2 selects input 2, and code 3 selects input 0. Alarms have no effect on the selection in this mode, and hold_req stays 0.
- R3: On the first clock with auto_en high after it was low, or after reset, sel_idx becomes the lowest-index usable input.
- R4: An input is unusable when its qualified los_alarm bit or its qualified fos_alarm bit is 1.
- R5: A change in an alarm level is qualified only after the new level has been held for 4 consecutive clocks. The selection reacts on the following clock, which is the 5th clock edge after the change. A pulse of 3 clocks or fewer has no effect.
- R6: In automatic mode, when the selected input becomes unusable, the selection moves to the usable input with the next larger index. If there is none, it moves to the lowest-index usable input.
- R7: While revert_en is low, automatic mode never moves to a higher-priority input while the selected input stays usable.
- R8: While revert_en is high, a usable input of higher priority than the selected one is taken on the next clock.
- R9: When the selected input fails and no input is usable, sel_idx is held and hold_req goes to 1. When any input becomes usable, hold_req clears and the lowest-index usable input is selected on the same clock.
- R10: active is the one-hot decode of sel_idx (bit i for input i) and does not depend on hold_flag. in_use equals active while hold_flag is 0 and is all zeros while hold_flag is 1.
- R11: switch_pulse is 1 for exactly the one cycle in which sel_idx first shows a new value, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| los_alarm | input | 3 | Loss-of-signal alarm level per input |
| fos_alarm | input | 3 | Frequency-offset alarm level per input |
| auto_en | input | 1 | 1 = automatic priority selection |
| revert_en | input | 1 | 1 = allow return to a recovered higher-priority input |
| man_sel | input | 2 | Manual select code |
| hold_flag | input | 1 | Digital-hold status of the downstream loop |
| sel_idx | output | 2 | Encoded selected input |
| active | output | 3 | One-hot selected-input indicators |
| in_use | output | 3 | Active indicators masked by hold_flag |
| hold_req | output | 1 | No usable input in automatic mode |
| switch_pulse | output | 1 | One-cycle pulse on a selection change |

## Verification
The hardest case to reach is the hold request. All three inputs must fail on the same qualified clock while the block is in automatic mode. If they fail one at a time, the block simply fails over instead. The stimulus asserts every loss-of-signal alarm in the same cycle, so all three qualifiers expire together. It then releases only the lowest-priority input, which shows that recovery selects the best usable input rather than the one that was held. A second path that is hard to reach is an upward fallback with revert off. It is reached by making the lowest-priority input the selected one and then failing it while a higher-priority input is already usable.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // Map a manual code onto a legal input index; out-of-range codes pick input 0.
   function automatic int unsigned clamp_code(input int unsigned code, input int unsigned n);
      return (code < n) ? code : 0;
   endfunction

endpackage

// File: rtl/rcs_alarm_qual.sv
module rcs_alarm_qual #(
   parameter int N_INPUTS = 3,
   parameter int FILT_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_INPUTS-1:0] raw_fail,
   output logic [N_INPUTS-1:0] fail_q
);
   localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

   if (FILT_CYC < 1) begin : g_bad_filt
      $error("rcs_alarm_qual: FILT_CYC must be at least 1");
   end

   for (genvar i = 0; i < N_INPUTS; i++) begin : g_ch
      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fail_q[i] <= 1'b0;
            else        fail_q[i] <= raw_fail[i];
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q     <= '0;
               fail_q[i] <= 1'b0;
            end else if (raw_fail[i] == fail_q[i]) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
               cnt_q     <= '0;
               fail_q[i] <= raw_fail[i];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end

      AST_QUAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(fail_q[i]) |-> ($past(raw_fail[i]) == fail_q[i])); // R5
   end

endmodule

// File: rtl/rcs_prio_pick.sv
module rcs_prio_pick #(
   parameter int N_INPUTS = 3,
   parameter int SEL_W    = 2
) (
   input  logic [N_INPUTS-1:0] healthy,
   input  logic [SEL_W-1:0]    cur,
   output logic [SEL_W-1:0]    best_idx,
   output logic                best_ok,
   output logic [SEL_W-1:0]    lower_idx,
   output logic                lower_ok
);
   always_comb begin
      best_idx  = '0;
      best_ok   = 1'b0;
      lower_idx = '0;
      lower_ok  = 1'b0;
      for (int i = N_INPUTS - 1; i >= 0; i--) begin
         if (healthy[i]) begin
            best_idx = SEL_W'(i);
            best_ok  = 1'b1;
            if (i > int'(cur)) begin
               lower_idx = SEL_W'(i);
               lower_ok  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rcs_onehot_dec.sv
module rcs_onehot_dec #(
   parameter int N_INPUTS = 3,
   parameter int SEL_W    = 2
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic                mask,
   output logic [N_INPUTS-1:0] hot,
   output logic [N_INPUTS-1:0] hot_masked
);
   for (genvar i = 0; i < N_INPUTS; i++) begin : g_bit
      assign hot[i]        = (sel == SEL_W'(i));
      assign hot_masked[i] = hot[i] & ~mask;
   end
endmodule

// File: rtl/refclk_prio_sel.sv
module refclk_prio_sel #(
   parameter int N_INPUTS = 3,
   parameter int FILT_CYC = 4,
   parameter int SEL_W    = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_INPUTS-1:0] los_alarm,
   input  logic [N_INPUTS-1:0] fos_alarm,
   input  logic                auto_en,
   input  logic                revert_en,
   input  logic [SEL_W-1:0]    man_sel,
   input  logic                hold_flag,
   output logic [SEL_W-1:0]    sel_idx,
   output logic [N_INPUTS-1:0] active,
   output logic [N_INPUTS-1:0] in_use,
   output logic                hold_req,
   output logic                switch_pulse
);
   import rcs_pkg::*;

   if (N_INPUTS < 2) begin : g_bad_n
      $error("refclk_prio_sel: N_INPUTS must be at least 2");
   end
   if ((1 << SEL_W) < N_INPUTS) begin : g_bad_w
      $error("refclk_prio_sel: SEL_W too narrow for N_INPUTS");
   end

   logic [N_INPUTS-1:0] fail_q, healthy;
   logic [SEL_W-1:0]    cur_q, nxt, best_idx, lower_idx, man_idx;
   logic                best_ok, lower_ok;
   logic                hold_q, hold_n, auto_q, sw_q;

   rcs_alarm_qual #(.N_INPUTS(N_INPUTS), .FILT_CYC(FILT_CYC)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_fail (los_alarm | fos_alarm),
      .fail_q   (fail_q)
   );

   assign healthy = ~fail_q;

   rcs_prio_pick #(.N_INPUTS(N_INPUTS), .SEL_W(SEL_W)) u_pick (
      .healthy   (healthy),
      .cur       (cur_q),
      .best_idx  (best_idx),
      .best_ok   (best_ok),
      .lower_idx (lower_idx),
      .lower_ok  (lower_ok)
   );

   assign man_idx = SEL_W'(clamp_code(int'(man_sel), N_INPUTS));

   always_comb begin
      nxt    = cur_q;
      hold_n = hold_q;
      if (!auto_en) begin
         nxt    = man_idx;
         hold_n = 1'b0;
      end else if (!auto_q || hold_q) begin
         if (best_ok) begin
            nxt    = best_idx;
            hold_n = 1'b0;
         end else begin
            hold_n = 1'b1;
         end
      end else if (!healthy[cur_q]) begin
         if (lower_ok)     nxt = lower_idx;
         else if (best_ok) nxt = best_idx;
         else              hold_n = 1'b1;
      end else if (revert_en && best_ok && (best_idx < cur_q)) begin
         nxt = best_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         hold_q <= 1'b0;
         auto_q <= 1'b0;
         sw_q   <= 1'b0;
      end else begin
         cur_q  <= nxt;
         hold_q <= hold_n;
         auto_q <= auto_en;
         sw_q   <= (nxt != cur_q);
      end
   end

   rcs_onehot_dec #(.N_INPUTS(N_INPUTS), .SEL_W(SEL_W)) u_dec (
      .sel        (cur_q),
      .mask       (hold_flag),
      .hot        (active),
      .hot_masked (in_use)
   );

   assign sel_idx      = cur_q;
   assign hold_req     = hold_q;
   assign switch_pulse = sw_q;

   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_q) < N_INPUTS); // R2
   AST_ACTIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(active) == 1); // R10
   AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_q) |-> switch_pulse); // R11
   AST_NO_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && auto_q && !revert_en && !hold_q && healthy[cur_q]) |=> $stable(cur_q)); // R7
   AST_HOLD_NONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req) |-> ($past(healthy) == '0)); // R9
   AST_MANUAL_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !hold_req); // R2

endmodule

// File: tb/sim_refclk_prio_sel.sv
`timescale 1ns/1ps
module sim_refclk_prio_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] los_alarm = '0, fos_alarm = '0;
   logic       auto_en = 1'b0, revert_en = 1'b0, hold_flag = 1'b0;
   logic [1:0] man_sel = '0;
   logic [1:0] sel_idx;
   logic [2:0] active, in_use;
   logic       hold_req, switch_pulse;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   refclk_prio_sel u0 (
      .clk(clk), .rst_n(rst_n), .los_alarm(los_alarm), .fos_alarm(fos_alarm),
      .auto_en(auto_en), .revert_en(revert_en), .man_sel(man_sel),
      .hold_flag(hold_flag), .sel_idx(sel_idx), .active(active), .in_use(in_use),
      .hold_req(hold_req), .switch_pulse(switch_pulse)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic t_reset;
      chk(sel_idx, 0, "R1 sel");
      chk(active, 1, "R1 active");
      chk(hold_req, 0, "R1 hold_req");
      chk(switch_pulse, 0, "R1 pulse");
   endtask

   task automatic t_manual;
      man_sel = 2'd1; tick(1);
      chk(sel_idx, 1, "R2 code1");
      chk(switch_pulse, 1, "R11 pulse on change");
      tick(1);
      chk(switch_pulse, 0, "R11 pulse one cycle");
      man_sel = 2'd2; tick(1);
      chk(sel_idx, 2, "R2 code2");
      chk(active, 4, "R10 active code2");
      man_sel = 2'd3; tick(1);
      chk(sel_idx, 0, "R2 code3 -> input0");
      los_alarm[0] = 1'b1; tick(8);
      chk(sel_idx, 0, "R2 alarm ignored in manual");
      chk(hold_req, 0, "R2 no hold in manual");
      los_alarm[0] = 1'b0; tick(6);
   endtask

   task automatic t_auto_entry;
      man_sel = 2'd2; tick(1);
      chk(sel_idx, 2, "R2 manual input2");
      auto_en = 1'b1; tick(1);
      chk(sel_idx, 0, "R3 entry picks input0");
      chk(switch_pulse, 1, "R11 pulse on entry");
      auto_en = 1'b0; tick(1);
      chk(sel_idx, 2, "R2 back to manual");
      fos_alarm[0] = 1'b1; tick(6);
      auto_en = 1'b1; tick(1);
      chk(sel_idx, 1, "R3 R4 entry skips failed input0");
      fos_alarm[0] = 1'b0; tick(10);
      chk(sel_idx, 1, "R7 no revert after recovery");
   endtask

   task automatic t_failover;
      los_alarm[1] = 1'b1; tick(4);
      chk(sel_idx, 1, "R5 not yet qualified");
      tick(1);
      chk(sel_idx, 2, "R6 moves to next lower");
      chk(switch_pulse, 1, "R11 pulse on failover");
      tick(1);
      chk(switch_pulse, 0, "R11 pulse cleared");
      fos_alarm[2] = 1'b1; tick(5);
      chk(sel_idx, 0, "R4 R6 fos alarm, fallback upward");
      los_alarm[1] = 1'b0; fos_alarm[2] = 1'b0; tick(6);
   endtask

   task automatic t_revert;
      los_alarm[0] = 1'b1; tick(5);
      chk(sel_idx, 1, "R6 input0 fails to input1");
      los_alarm[0] = 1'b0; tick(10);
      chk(sel_idx, 1, "R7 stays while revert low");
      chk(switch_pulse, 0, "R11 quiet while stable");
      revert_en = 1'b1; tick(1);
      chk(sel_idx, 0, "R8 revert to input0");
      chk(switch_pulse, 1, "R11 pulse on revert");
   endtask

   task automatic t_glitch;
      los_alarm[0] = 1'b1; tick(3);
      los_alarm[0] = 1'b0; tick(10);
      chk(sel_idx, 0, "R5 3-cycle glitch ignored");
   endtask

   task automatic t_hold;
      revert_en = 1'b0;
      los_alarm = 3'b111; tick(4);
      chk(hold_req, 0, "R5 hold not before qualification");
      tick(1);
      chk(hold_req, 1, "R9 hold raised");
      chk(sel_idx, 0, "R9 selection held");
      chk(switch_pulse, 0, "R11 no pulse on hold");
      los_alarm[2] = 1'b0; tick(4);
      chk(hold_req, 1, "R9 hold during requalify");
      tick(1);
      chk(hold_req, 0, "R9 hold cleared");
      chk(sel_idx, 2, "R9 best usable taken");
   endtask

   task automatic t_hold_flag;
      hold_flag = 1'b1; #1;
      chk(active, 4, "R10 active kept in hold");
      chk(in_use, 0, "R10 in_use masked");
      hold_flag = 1'b0; #1;
      chk(in_use, 4, "R10 in_use follows active");
   endtask

   initial begin
      #9 rst_n = 1'b1;
      tick(1);
      t_reset();
      t_manual();
      t_auto_entry();
      t_failover();
      t_revert();
      t_glitch();
      t_hold();
      t_hold_flag();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule